// File: doc/BRIEF.md
# Gated Timer/Counter with 13-bit Prescaled Mode

This block is a timer/counter of the kind found in small microcontrollers. A pair of 8-bit count registers advances either on ticks of a divided internal timer clock or on falling edges of an external event pin. A run bit enables counting. When the control field asks for gating, an external gate pin must also be high. Software can load either count register at any time. A register write always wins over an increment that falls in the same cycle.

Two counting layouts are supported. In the 13-bit layout, the low five bits of the low register form a modulo-32 prescaler whose carry advances the 8-bit high register. The top three bits of the low register take no part in counting. In the 16-bit layout, the two registers form one plain up-counter. A rollover from all ones to all zeros sets a sticky overflow flag, which serves as an interrupt request. That flag stays set until software clears it or an interrupt acknowledge arrives.

The timer clock is either the block clock itself or the block clock divided by two. A fixed divide-by-6 stage sits between the timer clock and the counter. The overflow period in the 13-bit layout is therefore 6 × (8192 − loaded value) timer-clock periods for a 13-bit loaded value.

Top module: `gtc_timer`

## Requirements
- R1: After reset both count registers read 0 and the overflow flag reads 0.
- R2: With the gate bit (ctl_i[3]) at 0, the count advances only while run_i is 1; with run_i at 0 the count registers hold.
- R3: With the gate bit at 1 and run_i at 1, counting happens only while gate_pin_i is high; the pin passes through a two-flop synchroniser first.
- R4: In timer mode (ctl_i[2] = 0) the count advances once per 6 timer-clock periods. The timer clock is clk when dbl_i = 1 and clk/2 when dbl_i = 0, so one increment takes 6 or 12 clk cycles of enabled time. The divider restarts whenever counting is disabled.
- R5: In counter mode (ctl_i[2] = 1) the count advances once per 1-to-0 transition of evt_pin_i, seen through a two-flop synchroniser. Each pin level must last at least two clk cycles.
- R6: Mode 00 (ctl_i[1:0]) counts {cnt_hi_o, cnt_lo_o[4:0]} as a 13-bit value: lo[4:0] wraps modulo 32 and carries into the high register. Counting never changes cnt_lo_o[7:5].
- R7: Mode 01 counts {cnt_hi_o, cnt_lo_o} as a 16-bit value.
- R8: Modes 10 and 11 never change the count registers by counting.
- R9: An increment from the all-ones count of the active layout wraps the count to zero and sets ovf_o.
- R10: ovf_o stays set until clr_ovf_i or irq_ack_i is high at a clock edge. A rollover in the same cycle as a clear leaves the flag set.
- R11: A write (wr_hi_i or wr_lo_i) stores wdata_i in the addressed register. An increment due in that same cycle is dropped for both registers and raises no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_i | input | 4 | [3] gate enable, [2] counter select, [1:0] mode |
| run_i | input | 1 | Run bit |
| gate_pin_i | input | 1 | External gate pin, asynchronous |
| evt_pin_i | input | 1 | External event pin, asynchronous |
| dbl_i | input | 1 | 1: timer clock is clk; 0: clk/2 |
| wr_hi_i | input | 1 | Write strobe for the high count register |
| wr_lo_i | input | 1 | Write strobe for the low count register |
| wdata_i | input | 8 | Write data |
| clr_ovf_i | input | 1 | Software clear of the overflow flag |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the overflow flag |
| cnt_hi_o | output | 8 | High count register |
| cnt_lo_o | output | 8 | Low count register |
| ovf_o | output | 1 | Overflow flag / interrupt request |

## Verification
The hardest case to reach is a register write that lands exactly on the clock edge where the divide-by-6 stage would produce an increment. The divider restarts whenever counting is disabled. Because of that, the bench raises run on a falling edge and counts five rising edges. It then places the write strobe on the sixth edge, where it collides with the increment. The gate and event inputs pass through synchronisers, so the bench holds each pin level for several cycles and leaves settling time before it compares. The rollover is reached by preloading values one or two steps below all ones, so that both layouts wrap within a few ticks.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

  typedef enum logic [1:0] {
    MODE_13B  = 2'd0,
    MODE_16B  = 2'd1,
    MODE_RSV2 = 2'd2,
    MODE_RSV3 = 2'd3
  } gtc_mode_e;

  typedef struct packed {
    logic      gate;
    logic      evt_sel;
    gtc_mode_e mode;
  } gtc_ctl_t;

endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/gtc_tick.sv
module gtc_tick #(
  parameter int PRE_DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic dbl_i,
  input  logic evt_mode_i,
  input  logic evt_fall_i,
  output logic tick_o
);

  localparam int DW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(PRE_DIV - 1);

  logic          half_q, half_d;
  logic [DW-1:0] div_q, div_d;
  logic          tclk_en;

  assign tclk_en = dbl_i | half_q;

  always_comb begin
    half_d = 1'b0;
    div_d  = '0;
    if (en_i) begin
      half_d = dbl_i ? 1'b0 : ~half_q;
      if (tclk_en) div_d = (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      else         div_d = div_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      div_q  <= '0;
    end else begin
      half_q <= half_d;
      div_q  <= div_d;
    end
  end

  assign tick_o = en_i & (evt_mode_i ? evt_fall_i
                                     : (tclk_en & (div_q == DIV_LAST)));

endmodule

// File: rtl/gtc_count.sv
module gtc_count
  import gtc_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  gtc_mode_e        mode_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             clr_i,
  output logic [REG_W-1:0] hi_o,
  output logic [REG_W-1:0] lo_o,
  output logic             ovf_o
);

  localparam int SW = REG_W + PRE_W;
  localparam int LW = 2 * REG_W;
  localparam int UW = REG_W - PRE_W;

  logic [REG_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic             ovf_q, ovf_d;
  logic [SW-1:0]    short_cnt, short_nxt;
  logic [LW-1:0]    long_cnt, long_nxt;
  logic             step, wrap;

  assign short_cnt = {hi_q, lo_q[PRE_W-1:0]};
  assign long_cnt  = {hi_q, lo_q};
  assign short_nxt = short_cnt + {{(SW-1){1'b0}}, 1'b1};
  assign long_nxt  = long_cnt + {{(LW-1){1'b0}}, 1'b1};
  assign step      = tick_i & ~wr_hi_i & ~wr_lo_i;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    wrap = 1'b0;
    if (step) begin
      unique case (mode_i)
        MODE_13B: begin
          hi_d = short_nxt[SW-1:PRE_W];
          lo_d = {lo_q[REG_W-1 -: UW], short_nxt[PRE_W-1:0]};
          wrap = &short_cnt;
        end
        MODE_16B: begin
          {hi_d, lo_d} = long_nxt;
          wrap = &long_cnt;
        end
        default: ;
      endcase
    end
    if (wr_hi_i) hi_d = wdata_i;
    if (wr_lo_i) lo_d = wdata_i;
    if (wrap)       ovf_d = 1'b1;
    else if (clr_i) ovf_d = 1'b0;
    else            ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      ovf_q <= ovf_d;
    end
  end

  assign hi_o  = hi_q;
  assign lo_o  = lo_q;
  assign ovf_o = ovf_q;

endmodule

// File: rtl/gtc_timer.sv
module gtc_timer
  import gtc_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int PRE_W   = 5,
  parameter int PRE_DIV = 6,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ctl_i,
  input  logic             run_i,
  input  logic             gate_pin_i,
  input  logic             evt_pin_i,
  input  logic             dbl_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             clr_ovf_i,
  input  logic             irq_ack_i,
  output logic [REG_W-1:0] cnt_hi_o,
  output logic [REG_W-1:0] cnt_lo_o,
  output logic             ovf_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_q_n;
  gtc_ctl_t   ctl;
  logic [1:0] pins_s;
  logic       gate_s, evt_s, evt_prev_q;
  logic       evt_fall, cnt_en, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  assign ctl = gtc_ctl_t'(ctl_i);

  gtc_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d_i   ({gate_pin_i, evt_pin_i}),
    .q_o   (pins_s)
  );
  assign {gate_s, evt_s} = pins_s;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) evt_prev_q <= 1'b0;
    else          evt_prev_q <= evt_s;
  end

  assign evt_fall = evt_prev_q & ~evt_s;
  assign cnt_en   = run_i & (~ctl.gate | gate_s);

  gtc_tick #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .en_i       (cnt_en),
    .dbl_i      (dbl_i),
    .evt_mode_i (ctl.evt_sel),
    .evt_fall_i (evt_fall),
    .tick_o     (tick)
  );

  gtc_count #(.REG_W(REG_W), .PRE_W(PRE_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .tick_i  (tick),
    .mode_i  (ctl.mode),
    .wr_hi_i (wr_hi_i),
    .wr_lo_i (wr_lo_i),
    .wdata_i (wdata_i),
    .clr_i   (clr_ovf_i | irq_ack_i),
    .hi_o    (cnt_hi_o),
    .lo_o    (cnt_lo_o),
    .ovf_o   (ovf_o)
  );

endmodule

// File: rtl/gtc_timer_chk.sv
module gtc_timer_chk #(
  parameter int REG_W = 8,
  parameter int PRE_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [1:0]       mode,
  input logic             wr_hi,
  input logic             wr_lo,
  input logic [REG_W-1:0] wdata,
  input logic             clr,
  input logic             ack,
  input logic [REG_W-1:0] hi,
  input logic [REG_W-1:0] lo,
  input logic             ovf
);

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_hi && !wr_lo) |=> ($stable(hi) && $stable(lo))); // R2

  AST_PRESCALE_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !wr_lo) |=> (lo[REG_W-1:PRE_W] == $past(lo[REG_W-1:PRE_W]))); // R6

  AST_LONG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !wr_hi && !wr_lo) |=>
      (({hi, lo} == $past({hi, lo})) || ({hi, lo} == $past({hi, lo}) + 1'b1))); // R7

  AST_SPARE_MODES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !wr_hi && !wr_lo) |=> ($stable(hi) && $stable(lo))); // R8

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> (hi == '0 && lo[PRE_W-1:0] == '0)); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr && !ack) |=> ovf); // R10

  AST_WRITE_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (hi == $past(wdata))); // R11

  AST_WRITE_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo == $past(wdata))); // R11

endmodule

bind gtc_timer gtc_timer_chk #(.REG_W(REG_W), .PRE_W(PRE_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_q_n),
  .run   (run_i),
  .mode  (ctl_i[1:0]),
  .wr_hi (wr_hi_i),
  .wr_lo (wr_lo_i),
  .wdata (wdata_i),
  .clr   (clr_ovf_i),
  .ack   (irq_ack_i),
  .hi    (cnt_hi_o),
  .lo    (cnt_lo_o),
  .ovf   (ovf_o)
);

// File: tb/gtc_timer_test.sv
module gtc_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ctl_i = 4'h0;
  logic       run_i = 1'b0, gate_pin_i = 1'b0, evt_pin_i = 1'b0, dbl_i = 1'b1;
  logic       wr_hi_i = 1'b0, wr_lo_i = 1'b0, clr_ovf_i = 1'b0, irq_ack_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] cnt_hi_o, cnt_lo_o;
  logic       ovf_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gtc_timer uut (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i), .run_i(run_i),
    .gate_pin_i(gate_pin_i), .evt_pin_i(evt_pin_i), .dbl_i(dbl_i),
    .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i), .wdata_i(wdata_i),
    .clr_ovf_i(clr_ovf_i), .irq_ack_i(irq_ack_i),
    .cnt_hi_o(cnt_hi_o), .cnt_lo_o(cnt_lo_o), .ovf_o(ovf_o)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       dbl;
    logic [7:0] hi0;
    logic [7:0] lo0;
    logic [7:0] nticks;
    logic [7:0] hi_e;
    logic [7:0] lo_e;
    logic       ovf_e;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 8'h00, 8'h00, 8'd3, 8'h00, 8'h03, 1'b0}, // R4 R6 base
    '{2'd0, 1'b0, 8'h00, 8'hFF, 8'd1, 8'h01, 8'hE0, 1'b0}, // R4 half clock, R6 carry, top bits kept
    '{2'd0, 1'b1, 8'hFF, 8'h1E, 8'd2, 8'h00, 8'h00, 1'b1}, // R9 13-bit wrap
    '{2'd0, 1'b1, 8'hFF, 8'h1E, 8'd1, 8'hFF, 8'h1F, 1'b0}, // R9 one short
    '{2'd1, 1'b1, 8'h00, 8'hFF, 8'd1, 8'h01, 8'h00, 1'b0}, // R7 carry
    '{2'd1, 1'b0, 8'hFF, 8'hFE, 8'd2, 8'h00, 8'h00, 1'b1}, // R7 R9 16-bit wrap
    '{2'd2, 1'b1, 8'h12, 8'h34, 8'd3, 8'h12, 8'h34, 1'b0}, // R8
    '{2'd3, 1'b1, 8'h56, 8'h78, 8'd3, 8'h56, 8'h78, 1'b0}, // R8
    '{2'd0, 1'b1, 8'h00, 8'hA5, 8'd4, 8'h00, 8'hA9, 1'b0}  // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk); wr_hi_i = 1'b1; wdata_i = hi;
    @(negedge clk); wr_hi_i = 1'b0; wr_lo_i = 1'b1; wdata_i = lo;
    @(negedge clk); wr_lo_i = 1'b0; clr_ovf_i = 1'b1;
    @(negedge clk); clr_ovf_i = 1'b0;
  endtask

  task automatic run_for(input int cyc);
    run_i = 1'b1;
    repeat (cyc) @(posedge clk);
    @(negedge clk); run_i = 1'b0;
  endtask

  task automatic pulse_evt(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt_pin_i = 1'b1;
      repeat (3) @(negedge clk);
      evt_pin_i = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 hi", {24'h0, cnt_hi_o}, 32'h0);
    check("R1 lo", {24'h0, cnt_lo_o}, 32'h0);
    check("R1 ovf", {31'h0, ovf_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: timer mode, R4 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      load(VECS[v].hi0, VECS[v].lo0);
      ctl_i = {2'b00, VECS[v].mode};
      dbl_i = VECS[v].dbl;
      run_for(int'(VECS[v].nticks) * (VECS[v].dbl ? 6 : 12));
      check($sformatf("R4/R6-R9 vec%0d count", v), {16'h0, cnt_hi_o, cnt_lo_o},
            {16'h0, VECS[v].hi_e, VECS[v].lo_e});
      check($sformatf("R9 vec%0d ovf", v), {31'h0, ovf_o}, {31'h0, VECS[v].ovf_e});
    end

    // R10: flag sticky, cleared by ack, then by software clear
    load(8'hFF, 8'h1F);
    ctl_i = 4'b0000; dbl_i = 1'b1;
    run_for(6);
    repeat (10) @(negedge clk);
    check("R10 sticky", {31'h0, ovf_o}, 32'h1);
    irq_ack_i = 1'b1; @(negedge clk); irq_ack_i = 1'b0;
    check("R10 ack clears", {31'h0, ovf_o}, 32'h0);
    load(8'hFF, 8'h1F);
    run_for(6);
    clr_ovf_i = 1'b1; @(negedge clk); clr_ovf_i = 1'b0;
    check("R10 clr clears", {31'h0, ovf_o}, 32'h0);

    // R11: write lands on the increment edge
    load(8'h00, 8'h00);
    ctl_i = 4'b0000; dbl_i = 1'b1;
    run_i = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); wr_lo_i = 1'b1; wdata_i = 8'h10;
    @(negedge clk); wr_lo_i = 1'b0; run_i = 1'b0;
    check("R11 write wins", {16'h0, cnt_hi_o, cnt_lo_o}, 32'h0010);

    // R5 R7: counter mode, 16-bit layout
    load(8'h00, 8'hFE);
    ctl_i = 4'b0101; run_i = 1'b1;
    pulse_evt(3);
    check("R5 R7 events", {16'h0, cnt_hi_o, cnt_lo_o}, 32'h0101);

    // R5 R6: counter mode, 13-bit layout
    run_i = 1'b0;
    load(8'h00, 8'h1F);
    ctl_i = 4'b0100; run_i = 1'b1;
    pulse_evt(2);
    check("R5 R6 events", {16'h0, cnt_hi_o, cnt_lo_o}, 32'h0101);

    // R3: gate pin low blocks, high allows
    run_i = 1'b0;
    load(8'h00, 8'h00);
    ctl_i = 4'b1101; gate_pin_i = 1'b0; run_i = 1'b1;
    pulse_evt(3);
    check("R3 gate low", {16'h0, cnt_hi_o, cnt_lo_o}, 32'h0000);
    gate_pin_i = 1'b1;
    repeat (4) @(negedge clk);
    pulse_evt(2);
    check("R3 gate high", {16'h0, cnt_hi_o, cnt_lo_o}, 32'h0002);

    // R2: run low, no gating, events ignored
    run_i = 1'b0; gate_pin_i = 1'b0;
    ctl_i = 4'b0101;
    pulse_evt(2);
    check("R2 run low", {16'h0, cnt_hi_o, cnt_lo_o}, 32'h0002);

    finish_run();
  end

endmodule